// File: doc/BRIEF.md
# Cycle-Stealing Bitmap Fetcher

This block shares an 8-bit processor memory bus with a host CPU. It reads a bitmap screen out of ordinary RAM and turns each byte into a serial pixel stream. Each pulse on the start-of-line input begins one fetch burst. The block raises a hold line that stops the host. It then turns on its address drivers in two steps, the low byte first and the upper nibble one clock later, and issues a fixed-rate train of active-low read strobes. When the burst ends it turns its drivers off and then lets the host resume.

The screen has two halves. Each half is one 256-byte page that can sit on any 256-byte boundary in a 4 KiB space, chosen by a 4-bit page number. The page number for a half is latched once, at the first burst of that half, and drives the upper nibble of the address for the whole half. The low byte of the address steps by one after every read and runs across bursts. When it wraps, fetching moves on to the other half.

The bytes that are read go to a shift register. The shift register presents them MSB first, one bit per pixel period. With the default parameters at a 50 MHz clock, one read cycle lasts 2.5 µs: the strobe is low for 1.5 µs and high for 1.0 µs.

Top module: `vid_fetch`

## Requirements
- R1: While reset is held, and right after it, hold_o, busy_o, addr_lo_oe_o, addr_hi_oe_o and pix_o are 0 and rd_n_o is 1.
- R2: A start-of-line pulse seen while idle sets hold_o and busy_o from the next clock. Pulses seen while busy are ignored, so every burst makes exactly BYTES_PER_BURST reads.
- R3: At the start of a burst, addr_lo_oe_o rises while addr_hi_oe_o is still 0, and addr_hi_oe_o rises one clock later. Before every strobe fall, addr_hi_oe_o is 1 and the address has been stable for at least SETUP_CYC clocks. The address does not change while rd_n_o is low.
- R4: Each read strobe is low for exactly STROBE_LO_CYC clocks. Inside a burst, the strobe stays high for exactly STROBE_HI_CYC clocks between reads.
- R5: Bits 7:0 of addr_o advance by one after each read. The count carries across bursts. After offset 0xFF it wraps to 0x00 and fetching moves to the other screen half.
- R6: Bits 11:8 of addr_o equal page0_i for the first half and page1_i for the second half. The page value is the one present when the first burst of that half was accepted. Later changes to the page inputs have no effect until the next half starts. The halves alternate first, second, first, and so on.
- R7: The byte on data_i is captured when rd_n_o rises. From that clock, pix_o shows bit 7 and then the following bits, MSB first, each for PIX_DIV clocks. After the eighth bit pix_o is 0 until the next capture.
- R8: At the end of a burst, both address drivers go off exactly one clock before hold_o falls.
- R9: While hold_o is 0, rd_n_o is 1 and both address drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sol_i | input | 1 | Start-of-line request; begins one burst |
| page0_i | input | 4 | Page number for the first screen half |
| page1_i | input | 4 | Page number for the second screen half |
| data_i | input | 8 | Read data from the memory bus |
| hold_o | output | 1 | Holds the host CPU off the bus while high |
| busy_o | output | 1 | A burst is in progress |
| addr_o | output | 12 | Fetch address |
| addr_lo_oe_o | output | 1 | Output enable for address bits 7:0 |
| addr_hi_oe_o | output | 1 | Output enable for address bits 11:8 |
| rd_n_o | output | 1 | Read strobe, active low |
| pix_o | output | 1 | Serial pixel output |

## Verification
A wrong low-byte offset or a wrong half flag shows at the next strobe, on addr_o, and it persists for every read after that. A page nibble latched at the wrong moment also shows at the next strobe, but it stays wrong only until the next half begins. A miscounted phase counter shows within one read cycle, as a strobe that is too short or too long, or as a burst with the wrong number of reads. A fault in the release order shows on the last clock of a burst. A fault in the shifter shows on pix_o within PIX_DIV times eight clocks of the capture.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_DRV_LO,
    ST_DRV_HI,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_REL
  } fetch_state_e;
endpackage

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int HOLD_CYC        = 2,
  parameter int SETUP_CYC       = 2,
  parameter int STROBE_LO_CYC   = 75,
  parameter int STROBE_HI_CYC   = 50,
  parameter int BYTES_PER_BURST = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sol_i,
  output logic accept_o,
  output logic cap_o,
  output logic hold_o,
  output logic busy_o,
  output logic lo_oe_o,
  output logic hi_oe_o,
  output logic rd_n_o
);
  localparam int M1   = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
  localparam int M2   = (STROBE_LO_CYC > STROBE_HI_CYC) ? STROBE_LO_CYC : STROBE_HI_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(BYTES_PER_BURST + 1);

  fetch_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] nbyte_q, nbyte_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    nbyte_d  = nbyte_q;
    accept_o = 1'b0;
    cap_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        nbyte_d = '0;
        cnt_d   = '0;
        if (sol_i) begin
          accept_o = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cnt_q == CW'(HOLD_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_DRV_LO;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DRV_LO: state_d = ST_DRV_HI;
      ST_DRV_HI: begin
        cnt_d   = '0;
        state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_q == CW'(SETUP_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_LOW;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_LOW: begin
        if (cnt_q == CW'(STROBE_LO_CYC - 1)) begin
          cap_o   = 1'b1;
          cnt_d   = '0;
          nbyte_d = nbyte_q + 1'b1;
          state_d = ST_HIGH;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_HIGH: begin
        if (cnt_q == CW'(STROBE_HI_CYC - 1)) begin
          cnt_d   = '0;
          state_d = (nbyte_q == BW'(BYTES_PER_BURST)) ? ST_REL : ST_LOW;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      nbyte_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nbyte_q <= nbyte_d;
    end
  end

  assign hold_o  = (state_q != ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);
  assign lo_oe_o = (state_q inside {ST_DRV_LO, ST_DRV_HI, ST_SETUP, ST_LOW, ST_HIGH});
  assign hi_oe_o = (state_q inside {ST_DRV_HI, ST_SETUP, ST_LOW, ST_HIGH});
  assign rd_n_o  = (state_q != ST_LOW);

  // upper nibble driver never on without the low byte driver
  p_hi_after_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_oe_o |-> lo_oe_o);
  p_lo_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_oe_o) |-> !hi_oe_o);
  p_strobe_in_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (hold_o && hi_oe_o));
  p_release_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (!$past(lo_oe_o) && !$past(hi_oe_o)));
endmodule

// File: rtl/fetch_addr.sv
module fetch_addr #(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              cap_i,
  input  logic [PAGE_W-1:0] page0_i,
  input  logic [PAGE_W-1:0] page1_i,
  output logic [PAGE_W+OFF_W-1:0] addr_o
);
  logic              half_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      off_q  <= '0;
      hi_q   <= '0;
    end else begin
      // page latched only when a half begins
      if (accept_i && (off_q == '0)) hi_q <= half_q ? page1_i : page0_i;
      if (cap_i) begin
        off_q <= off_q + 1'b1;
        if (&off_q) half_q <= ~half_q;
      end
    end
  end

  assign addr_o = {hi_q, off_q};
endmodule

// File: rtl/pix_shift.sv
module pix_shift #(
  parameter int DATA_W  = 8,
  parameter int PIX_DIV = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pix_o
);
  localparam int PDW = $clog2(PIX_DIV + 1);

  logic [DATA_W-1:0] sh_q;
  logic [PDW-1:0]    div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      div_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      div_q <= '0;
    end else if (div_q == PDW'(PIX_DIV - 1)) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign pix_o = sh_q[DATA_W-1];
endmodule

// File: rtl/vid_fetch.sv
module vid_fetch #(
  parameter int PAGE_W          = 4,
  parameter int OFF_W           = 8,
  parameter int DATA_W          = 8,
  parameter int HOLD_CYC        = 2,
  parameter int SETUP_CYC       = 2,
  parameter int STROBE_LO_CYC   = 75,
  parameter int STROBE_HI_CYC   = 50,
  parameter int BYTES_PER_BURST = 32,
  parameter int PIX_DIV         = 15,
  localparam int AW = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sol_i,
  input  logic [PAGE_W-1:0] page0_i,
  input  logic [PAGE_W-1:0] page1_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hold_o,
  output logic              busy_o,
  output logic [AW-1:0]     addr_o,
  output logic              addr_lo_oe_o,
  output logic              addr_hi_oe_o,
  output logic              rd_n_o,
  output logic              pix_o
);
  logic accept, cap;

  fetch_seq #(
    .HOLD_CYC       (HOLD_CYC),
    .SETUP_CYC      (SETUP_CYC),
    .STROBE_LO_CYC  (STROBE_LO_CYC),
    .STROBE_HI_CYC  (STROBE_HI_CYC),
    .BYTES_PER_BURST(BYTES_PER_BURST)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sol_i   (sol_i),
    .accept_o(accept),
    .cap_o   (cap),
    .hold_o  (hold_o),
    .busy_o  (busy_o),
    .lo_oe_o (addr_lo_oe_o),
    .hi_oe_o (addr_hi_oe_o),
    .rd_n_o  (rd_n_o)
  );

  fetch_addr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) i_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .cap_i   (cap),
    .page0_i (page0_i),
    .page1_i (page1_i),
    .addr_o  (addr_o)
  );

  pix_shift #(.DATA_W(DATA_W), .PIX_DIV(PIX_DIV)) i_pix (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cap),
    .data_i(data_i),
    .pix_o (pix_o)
  );

  p_addr_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable(addr_o));
  p_page_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_oe_o && $past(addr_hi_oe_o)) |-> $stable(addr_o[AW-1:OFF_W]));
  p_offset_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |-> (addr_o[OFF_W-1:0] == $past(addr_o[OFF_W-1:0]) + 1'b1));
  p_msb_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |-> (pix_o == $past(data_i[DATA_W-1])));
  p_quiet_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |-> (rd_n_o && !addr_lo_oe_o && !addr_hi_oe_o));
endmodule

// File: tb/test_vid_fetch.sv
module test_vid_fetch;
  localparam int HOLD = 2, SETUP = 2, LO = 10, HI = 8, BPB = 32, PDIV = 2;
  localparam int LINES = 20;

  logic clk = 1'b0, rst_ni = 1'b0, sol = 1'b0;
  logic [3:0] page0 = '0, page1 = '0;
  logic [7:0] data;
  logic hold, busy, lo_oe, hi_oe, rd_n, pix;
  logic [11:0] addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] fdat(logic [11:0] a);
    return 8'(a[7:0] * 8'd37) ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign data = (!rd_n && hi_oe) ? fdat(addr) : 8'h00;

  vid_fetch #(
    .HOLD_CYC(HOLD), .SETUP_CYC(SETUP), .STROBE_LO_CYC(LO),
    .STROBE_HI_CYC(HI), .BYTES_PER_BURST(BPB), .PIX_DIV(PDIV)
  ) i_vid_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .sol_i(sol), .page0_i(page0), .page1_i(page1),
    .data_i(data), .hold_o(hold), .busy_o(busy), .addr_o(addr),
    .addr_lo_oe_o(lo_oe), .addr_hi_oe_o(hi_oe), .rd_n_o(rd_n), .pix_o(pix)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // port monitor, sampled on falling edges
  logic p_rd = 1, p_hold = 0, p_lo = 0, p_hi = 0, p2_lo = 0;
  logic [11:0] p_addr = '0, rd_addr = '0;
  int low_cnt = 0, high_cnt = 0, reads = 0, total = 0, stab = 0;
  int pix_idx = -1;
  logic [7:0] pix_byte = '0;
  logic [7:0] exp_off = '0;
  logic exp_half = 0, addr_moved = 0;
  logic [3:0] exp_hi = '0;

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (!hold) chk(rd_n && !lo_oe && !hi_oe, "R9 idle bus", {rd_n, lo_oe, hi_oe}, 3'b100);
      if (hold && !p_hold) begin
        reads = 0;
        if (exp_off == 8'h00) exp_hi = exp_half ? page1 : page0;
      end
      if (lo_oe && !p_lo) chk(!hi_oe, "R3 low byte first", hi_oe, 0);
      if (hi_oe && !p_hi) chk(p_lo, "R3 upper one clock later", p_lo, 1);
      if (!rd_n && p_rd) begin
        chk(stab >= SETUP && p_hi, "R3 setup", stab, SETUP);
        if (reads > 0) chk(high_cnt == HI, "R4 high width", high_cnt, HI);
        low_cnt = 0;
        rd_addr = addr;
        addr_moved = 0;
      end
      if (!rd_n) begin
        low_cnt++;
        if (addr != rd_addr) addr_moved = 1;
      end
      if (rd_n && !p_rd) begin
        chk(low_cnt == LO, "R4 low width", low_cnt, LO);
        chk(!addr_moved, "R3 addr stable in strobe", addr_moved, 0);
        chk(rd_addr[7:0] == exp_off, "R5 offset", rd_addr[7:0], exp_off);
        chk(rd_addr[11:8] == exp_hi, "R6 page", rd_addr[11:8], exp_hi);
        pix_byte = fdat(rd_addr);
        pix_idx  = 0;
        exp_off  = exp_off + 8'd1;
        if (exp_off == 8'h00) exp_half = ~exp_half;
        reads++;
        total++;
        high_cnt = 0;
      end else if (pix_idx >= 0) pix_idx++;
      if (rd_n && hold) high_cnt++;
      if (pix_idx >= 0 && pix_idx < 16)
        chk(pix == pix_byte[7 - pix_idx / 2], "R7 pixel bit", pix, pix_byte[7 - pix_idx / 2]);
      else if (pix_idx == 16) chk(pix == 1'b0, "R7 zero fill", pix, 0);
      if (!hold && p_hold) begin
        chk(!p_lo && !p_hi && p2_lo, "R8 release order", {p2_lo, p_lo}, 2'b10);
        chk(reads == BPB, "R2 reads per burst", reads, BPB);
      end
      if (hi_oe && rd_n) stab = (p_hi && addr == p_addr) ? stab + 1 : 1;
      else stab = 0;
    end
    p2_lo  = p_lo;
    p_lo   = lo_oe;
    p_hi   = hi_oe;
    p_rd   = rd_n;
    p_hold = hold;
    p_addr = addr;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!hold && !busy && rd_n && !lo_oe && !hi_oe && !pix, "R1 in reset",
        {hold, busy, rd_n, lo_oe, hi_oe, pix}, 6'b001000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!hold && !busy && rd_n && !lo_oe && !hi_oe && !pix, "R1 after reset",
        {hold, busy, rd_n, lo_oe, hi_oe, pix}, 6'b001000);
    for (int ln = 0; ln < LINES; ln++) begin
      while (busy) @(negedge clk);
      repeat ($urandom_range(1, 6)) @(negedge clk);
      if (ln == 0) begin page0 = 4'h0; page1 = 4'hF; end
      else begin page0 = 4'($urandom); page1 = 4'($urandom); end
      sol = 1'b1;
      @(negedge clk);
      sol = 1'b0;
      chk(hold && busy, "R2 start", {hold, busy}, 2'b11);
      for (int k = 0; k < 3; k++) begin
        repeat ($urandom_range(20, 150)) @(negedge clk);
        if (busy) begin
          sol = 1'b1;
          page0 = 4'($urandom);
          page1 = 4'($urandom);
          @(negedge clk);
          sol = 1'b0;
        end
      end
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(total == LINES * BPB, "R5 total reads", total, LINES * BPB);
    chk(!hold && rd_n, "R9 final idle", {hold, rd_n}, 2'b01);
    done = 1;
    summary();
    $finish;
  end
endmodule